// File: doc/BRIEF.md
# Double-Buffered Timing Phase Oscillator Control

This block holds the programming state of a timing numerically controlled oscillator and runs the oscillator itself. All of it works on the processor clock. A processor bus writes staged ("holding") copies of an 8-bit phase offset and a 32-bit frequency word. These writes do not reach the oscillator. A value takes effect only when it is copied into the matching active register. For the frequency, a write to its strobe address does the copy. For the phase offset, the copy comes from a write to its own strobe address, or from an external sync pulse when a configuration bit permits it.

A 32-bit phase accumulator adds the active frequency on every cycle where the advance enable is high. The output phase is the accumulator's top 8 bits plus the active offset, computed to 9 bits. The offset covers one full input period. A format bit selects how it is read: as a signed value covering ±T/2, or as an unsigned value covering 0 to T. The ninth output bit therefore shows whether the offset carried the phase past, or below, the current period.

Top module: `timing_nco_ctrl`

## Requirements
- R1: Reset clears both holding registers, both active registers, the configuration register and the accumulator, so `phaseOut`, `activeFreq` and `activeOfs` read zero.
- R2: A write to address 0 loads `wrData[7:0]` into the offset holding register only; `activeOfs` keeps its value.
- R3: A write of any data to address 3 copies the offset holding register into `activeOfs`, visible one cycle after the write.
- R4: A write to address 1 loads `wrData[31:0]` into the frequency holding register only; `activeFreq` keeps its value.
- R5: A write of any data to address 2 copies the frequency holding register into `activeFreq`, visible one cycle after the write.
- R6: A cycle with `syncIn` high copies the offset holding register into `activeOfs` when configuration bit 0 (sync enable) is 1. When that bit is 0, `syncIn` has no effect.
- R7: An address-3 write and an enabled sync in the same cycle produce one transfer, and `activeOfs` equals the holding value.
- R8: The accumulator adds `activeFreq` modulo 2^32 on each cycle with `advEn` high and holds otherwise.
- R9: `phaseOut` equals {0, accumulator[31:24]} plus the offset, modulo 2^9. The offset is zero-extended when configuration bit 1 is 0 (offset binary) and sign-extended from bit 7 when that bit is 1 (two's complement).
- R10: An enabled sync in the same cycle as an address-0 write transfers the previous holding value, not the one being written.
- R11: A write to address 4 loads configuration bit 0 (sync enable) and bit 1 (format) from `wrData[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| syncIn | input | 1 | External sync, sampled each cycle |
| advEn | input | 1 | Accumulator advance enable |
| phaseOut | output | 9 | Accumulator top bits plus extended offset |
| activeFreq | output | 32 | Active frequency word |
| activeOfs | output | 8 | Active phase offset |

## Verification
The bench sends an offset of 0x80 through both formats. A design that ignored the format bit would return 0x085 in both cases instead of 0x185 in the signed case. It also drives a sync pulse while sync is disabled, and one in the same cycle as a holding-register write. A design that leaked the pulse, or that forwarded the freshly written data, would change `activeOfs` to the wrong value. A simultaneous strobe and sync must leave exactly the holding value in the active register. A 255-cycle run checks that the top phase bits wrap cleanly, so any stall or double step would shift the result.

// File: rtl/tnco_pkg.sv
package tnco_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_OFS_HOLD = 3'd0;
  localparam logic [ADDR_W-1:0] A_FRQ_HOLD = 3'd1;
  localparam logic [ADDR_W-1:0] A_FRQ_STB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_OFS_STB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG      = 3'd4;

  // One-cycle commands from control to datapath
  typedef struct packed {
    logic ldOfs;
    logic ldFrq;
    logic moveOfs;
    logic moveFrq;
  } ctlStrobe_t;
endpackage

// File: rtl/tnco_ctl.sv
module tnco_ctl
  import tnco_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        cfgBits,
  input  logic              syncIn,
  output ctlStrobe_t        stb,
  output logic              fmtTwos
);
  logic syncEn;
  logic hitOfsHold, hitFrqHold, hitFrqStb, hitOfsStb, hitCfg;

  always_comb begin
    hitOfsHold = wrEn && (wrAddr == A_OFS_HOLD);
    hitFrqHold = wrEn && (wrAddr == A_FRQ_HOLD);
    hitFrqStb  = wrEn && (wrAddr == A_FRQ_STB);
    hitOfsStb  = wrEn && (wrAddr == A_OFS_STB);
    hitCfg     = wrEn && (wrAddr == A_CFG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncEn  <= 1'b0;
      fmtTwos <= 1'b0;
    end else if (hitCfg) begin
      syncEn  <= cfgBits[0];
      fmtTwos <= cfgBits[1];
    end
  end

  // Strobe and qualified sync merge into a single transfer
  always_comb begin
    stb.ldOfs   = hitOfsHold;
    stb.ldFrq   = hitFrqHold;
    stb.moveFrq = hitFrqStb;
    stb.moveOfs = hitOfsStb || (syncIn && syncEn);
  end
endmodule

// File: rtl/tnco_dp.sv
module tnco_dp
  import tnco_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 8,
  localparam int PH_W  = OFS_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [FREQ_W-1:0] wrData,
  input  logic              advEn,
  input  logic              fmtTwos,
  output logic [PH_W-1:0]   phaseOut,
  output logic [FREQ_W-1:0] activeFreq,
  output logic [OFS_W-1:0]  activeOfs
);
  logic [OFS_W-1:0]  holdOfs;
  logic [FREQ_W-1:0] holdFrq;
  logic [ACC_W-1:0]  acc;
  logic [PH_W-1:0]   ofsExt;
  logic [PH_W-1:0]   accTop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdOfs    <= '0;
      holdFrq    <= '0;
      activeOfs  <= '0;
      activeFreq <= '0;
    end else begin
      if (stb.ldOfs)   holdOfs    <= wrData[OFS_W-1:0];
      if (stb.ldFrq)   holdFrq    <= wrData;
      if (stb.moveOfs) activeOfs  <= holdOfs;
      if (stb.moveFrq) activeFreq <= holdFrq;
    end
  end

  generate
    if (FREQ_W >= ACC_W) begin : g_freqWide
      always_ff @(posedge clk) begin
        if (!rstN)      acc <= '0;
        else if (advEn) acc <= acc + activeFreq[ACC_W-1:0];
      end
    end else begin : g_freqNarrow
      always_ff @(posedge clk) begin
        if (!rstN)      acc <= '0;
        else if (advEn) acc <= acc + {{(ACC_W-FREQ_W){1'b0}}, activeFreq};
      end
    end
  endgenerate

  always_comb begin
    ofsExt   = fmtTwos ? {activeOfs[OFS_W-1], activeOfs} : {1'b0, activeOfs};
    accTop   = {1'b0, acc[ACC_W-1 -: OFS_W]};
    phaseOut = accTop + ofsExt;
  end
endmodule

// File: rtl/timing_nco_ctrl.sv
module timing_nco_ctrl
  import tnco_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 8,
  localparam int PH_W  = OFS_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [FREQ_W-1:0] wrData,
  input  logic              syncIn,
  input  logic              advEn,
  output logic [PH_W-1:0]   phaseOut,
  output logic [FREQ_W-1:0] activeFreq,
  output logic [OFS_W-1:0]  activeOfs
);
  ctlStrobe_t stb;
  logic       fmtTwos;

  tnco_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .cfgBits (wrData[1:0]),
    .syncIn  (syncIn),
    .stb     (stb),
    .fmtTwos (fmtTwos)
  );

  tnco_dp #(.FREQ_W(FREQ_W), .ACC_W(ACC_W), .OFS_W(OFS_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .advEn      (advEn),
    .fmtTwos    (fmtTwos),
    .phaseOut   (phaseOut),
    .activeFreq (activeFreq),
    .activeOfs  (activeOfs)
  );
endmodule

// File: rtl/tnco_chk.sv
module tnco_chk
  import tnco_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 8
)(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              syncIn,
  input logic              advEn,
  input logic              syncEn,
  input logic [OFS_W-1:0]  holdOfs,
  input logic [FREQ_W-1:0] holdFrq,
  input logic [ACC_W-1:0]  acc,
  input logic [FREQ_W-1:0] activeFreq,
  input logic [OFS_W-1:0]  activeOfs
);
  // R2
  ofs_hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_OFS_HOLD && !syncIn) |=> $stable(activeOfs));

  // R3
  ofs_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_OFS_STB) |=> activeOfs == $past(holdOfs));

  // R4
  frq_hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == A_FRQ_STB) |=> $stable(activeFreq));

  // R5
  frq_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_FRQ_STB) |=> activeFreq == $past(holdFrq));

  // R6
  sync_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && !syncEn && !(wrEn && wrAddr == A_OFS_STB)) |=> $stable(activeOfs));

  // R6
  sync_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && syncEn) |=> activeOfs == $past(holdOfs));

  // R8
  acc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    advEn |=> acc == $past(acc) + ACC_W'($past(activeFreq)));

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !advEn |=> $stable(acc));
endmodule

bind timing_nco_ctrl tnco_chk #(.FREQ_W(FREQ_W), .ACC_W(ACC_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .syncIn     (syncIn),
  .advEn      (advEn),
  .syncEn     (u_ctl.syncEn),
  .holdOfs    (u_dp.holdOfs),
  .holdFrq    (u_dp.holdFrq),
  .acc        (u_dp.acc),
  .activeFreq (activeFreq),
  .activeOfs  (activeOfs)
);

// File: tb/timing_nco_ctrl_tb.sv
module timing_nco_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        syncIn = 1'b0;
  logic        advEn = 1'b0;
  logic [8:0]  phaseOut;
  logic [31:0] activeFreq;
  logic [7:0]  activeOfs;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_P/2) clk = ~clk;

  timing_nco_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syncIn(syncIn), .advEn(advEn), .phaseOut(phaseOut),
    .activeFreq(activeFreq), .activeOfs(activeOfs)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs from a falling edge; returns at the next falling edge
  task automatic cycle(logic we, logic [2:0] a, logic [31:0] d, logic s);
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d; syncIn = s;
    @(negedge clk);
    wrEn = 1'b0; syncIn = 1'b0;
  endtask

  task automatic run(int n);
    @(negedge clk);
    advEn = 1'b1;
    repeat (n) @(negedge clk);
    advEn = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 phaseOut", 32'(phaseOut), 0);
    check("R1 activeFreq", activeFreq, 0);
    check("R1 activeOfs", 32'(activeOfs), 0);
  endtask

  task automatic t_offsetPath();
    cycle(1, 3'd0, 32'h0000_005A, 0);
    check("R2 hold write leaves active", 32'(activeOfs), 0);
    cycle(1, 3'd3, 32'hDEAD_BEEF, 0);
    check("R3 strobe copies offset", 32'(activeOfs), 32'h5A);
  endtask

  task automatic t_freqPath();
    cycle(1, 3'd1, 32'h0100_0000, 0);
    check("R4 hold write leaves active", activeFreq, 0);
    cycle(1, 3'd2, 32'h0, 0);
    check("R5 strobe copies frequency", activeFreq, 32'h0100_0000);
  endtask

  task automatic t_accumulate();
    run(5);
    check("R8/R9 five steps", 32'(phaseOut), 32'h05F);
    repeat (3) @(negedge clk);
    check("R8 hold when disabled", 32'(phaseOut), 32'h05F);
  endtask

  task automatic t_format();
    cycle(1, 3'd0, 32'h80, 0);
    cycle(1, 3'd3, 32'h0, 0);
    check("R9 offset binary", 32'(phaseOut), 32'h085);
    cycle(1, 3'd4, 32'h2, 0);
    check("R9/R11 two's complement", 32'(phaseOut), 32'h185);
  endtask

  task automatic t_sync();
    cycle(1, 3'd0, 32'h10, 0);
    cycle(0, 3'd0, 32'h0, 1);
    check("R6 sync ignored when disabled", 32'(activeOfs), 32'h80);
    cycle(1, 3'd4, 32'h3, 0);
    cycle(0, 3'd0, 32'h0, 1);
    check("R6/R11 sync copies when enabled", 32'(activeOfs), 32'h10);
  endtask

  task automatic t_strobeAndSync();
    cycle(1, 3'd0, 32'h22, 0);
    cycle(1, 3'd3, 32'h0, 1);
    check("R7 single merged transfer", 32'(activeOfs), 32'h22);
    check("R7 phase after merge", 32'(phaseOut), 32'h027);
  endtask

  task automatic t_holdDuringSync();
    cycle(1, 3'd0, 32'h33, 1);
    check("R10 sync takes previous hold", 32'(activeOfs), 32'h22);
    cycle(1, 3'd3, 32'h0, 0);
    check("R10 new hold after strobe", 32'(activeOfs), 32'h33);
  endtask

  task automatic t_wrap();
    run(255);
    check("R8 accumulator wrap", 32'(phaseOut), 32'h037);
    cycle(1, 3'd0, 32'hF0, 0);
    cycle(1, 3'd3, 32'h0, 0);
    check("R9 negative offset", 32'(phaseOut), 32'h1F4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_offsetPath();
    t_freqPath();
    t_accumulate();
    t_format();
    t_sync();
    t_strobeAndSync();
    t_holdDuringSync();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule